// File: doc/BRIEF.md
# Three-Stage Pipeline Hazard Controller

This block is the hazard controller of a three-stage pipeline: fetch/decode, execute and memory/writeback, with two pipeline registers (ID/EX and EX/MEM) between the stages. Each cycle it compares the register fields of the instruction being decoded with the destination of the instruction one stage ahead, which is held in EX/MEM. From that comparison it chooses whether each ALU operand takes the EX/MEM result. When that older instruction is a load, it instead holds the PC and turns the next ID/EX entry into a no-op.

Branches are predicted not taken. Fetch runs sequentially, and a branch that falls through costs nothing. A branch that resolves taken redirects the PC to the branch target and squashes the wrong-path work for exactly two cycles. The block owns the control half of the ID/EX register and the PC register, so a no-op is visible as an all-zero control word.

Top module: `hzd_ctrl3`

## Requirements
- R1: In the cycle after reset is released, with idle inputs, `ex_ctrl` is all zero, `pc` is 0, and `pc_hold`, `flush` and `bubble` are 0.
- R2: `fwd_a` is 1 in the same cycle when `mem_wr` is 1, `mem_dst` is non-zero, `mem_dst` equals `dec_rt`, and no stall is raised.
- R3: `fwd_b` is 1 in the same cycle when `mem_wr` is 1, `mem_dst` is non-zero, `mem_dst` equals `dec_rd`, and no stall is raised.
- R4: No forward select and no stall is raised when `mem_wr` is 0 or `mem_dst` is register 0.
- R5: A load (`mem_load`=1) whose destination would be forwarded under R2 or R3 raises `pc_hold` and `bubble` in the same cycle and clears both forward selects. At the next edge `pc` keeps its value and `ex_ctrl` becomes all zero.
- R6: A stall lasts exactly one cycle. If the same load-use inputs are still present in the next cycle, no stall is raised and the matching forward select is 1.
- R7: With no stall and no flush, `ex_ctrl` captures `dec_ctrl` and `pc` advances by 4 at each edge.
- R8: A taken branch (`br_taken`=1) raises `flush` and `bubble` in its own cycle and in the next cycle (two cycles in total). `pc` loads `br_target` at the first edge and then advances by 4. `ex_ctrl` is zero after both edges.
- R9: `br_taken` is ignored in the second flush cycle: `pc` is not reloaded and flushing ends after the two cycles.
- R10: When a load-use stall and a taken branch fall in the same cycle, the flush wins: `pc_hold` is 0, `flush` is 1, and `pc` loads `br_target`.
- R11: When `br_taken` is 0 the controller raises no flush, so sequential fetch costs no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dec_rt | input | REG_W | rt field of the decoding instruction (operand A source) |
| dec_rd | input | REG_W | rd field of the decoding instruction (operand B source) |
| dec_ctrl | input | CTRL_W | Control word decoded for the instruction entering ID/EX |
| mem_dst | input | REG_W | Destination register held in EX/MEM |
| mem_wr | input | 1 | EX/MEM instruction writes a register |
| mem_load | input | 1 | EX/MEM instruction is a load |
| br_taken | input | 1 | Branch resolved taken this cycle |
| br_target | input | PC_W | Redirect address for a taken branch |
| fwd_a | output | 1 | Operand A takes the EX/MEM result |
| fwd_b | output | 1 | Operand B takes the EX/MEM result |
| pc_hold | output | 1 | PC keeps its value at the next edge |
| bubble | output | 1 | ID/EX control is loaded with a no-op |
| flush | output | 1 | Wrong-path squash in progress |
| ex_ctrl | output | CTRL_W | ID/EX control register contents |
| pc | output | PC_W | Program counter |

## Verification
The load-use stall and the taken-branch flush can both be raised in the same cycle. The bench provokes this by presenting a load whose destination matches `dec_rt` while `br_taken` is high. It then checks that `pc_hold` stays low, that `flush` is high, and that `pc` takes the branch target at the next edge rather than holding. A second overlap, a taken branch presented during the refill cycle, is driven with a different target and judged by the PC continuing sequentially from the first target.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  // Why the ID/EX entry is being replaced with a no-op this cycle.
  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_LOAD_USE = 2'd1,
    CAUSE_BRANCH   = 2'd2
  } hzd_cause_e;
endpackage

// File: rtl/hzd_fwd_unit.sv
// Compares each source field of the decoding instruction against the
// EX/MEM destination; one comparator per source.
module hzd_fwd_unit #(
  parameter int REG_W = 5,
  parameter int N_SRC = 2
) (
  input  logic [REG_W-1:0] src_reg [N_SRC],
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wr,
  output logic [N_SRC-1:0] hit
);
  logic live;
  assign live = mem_wr && (mem_dst != '0);

  for (genvar i = 0; i < N_SRC; i++) begin : g_cmp
    assign hit[i] = live && (src_reg[i] == mem_dst);
  end
endmodule

// File: rtl/hzd_stall_unit.sv
// Load-use detector with a one-cycle limit; a flush drops the stall.
module hzd_stall_unit (
  input  logic clk,
  input  logic rst,
  input  logic mem_load,
  input  logic any_hit,
  input  logic flushing,
  output logic stall
);
  logic stalled_q;

  assign stall = mem_load && any_hit && !stalled_q && !flushing;

  always_ff @(posedge clk) begin
    if (rst) stalled_q <= 1'b0;
    else     stalled_q <= stall;
  end
endmodule

// File: rtl/hzd_redirect.sv
// Taken-branch squash sequencer: FLUSH_CYC cycles of flush per accepted branch.
module hzd_redirect #(
  parameter int FLUSH_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic br_taken,
  output logic accept,
  output logic flushing
);
  localparam int CNT_W = $clog2(FLUSH_CYC + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(FLUSH_CYC - 1);

  logic [CNT_W-1:0] left_q;
  logic             refilling;

  assign refilling = (left_q != '0);
  assign accept    = br_taken && !refilling;
  assign flushing  = accept || refilling;

  always_ff @(posedge clk) begin
    if (rst)            left_q <= '0;
    else if (accept)    left_q <= RELOAD;
    else if (refilling) left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/hzd_ctrl3.sv
module hzd_ctrl3
  import hzd_pkg::*;
#(
  parameter int REG_W     = 5,
  parameter int CTRL_W    = 8,
  parameter int PC_W      = 16,
  parameter int PC_STEP   = 4,
  parameter int FLUSH_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_W-1:0]  dec_rt,
  input  logic [REG_W-1:0]  dec_rd,
  input  logic [CTRL_W-1:0] dec_ctrl,
  input  logic [REG_W-1:0]  mem_dst,
  input  logic              mem_wr,
  input  logic              mem_load,
  input  logic              br_taken,
  input  logic [PC_W-1:0]   br_target,
  output logic              fwd_a,
  output logic              fwd_b,
  output logic              pc_hold,
  output logic              bubble,
  output logic              flush,
  output logic [CTRL_W-1:0] ex_ctrl,
  output logic [PC_W-1:0]   pc
);
  localparam int N_SRC = 2;
  localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

  logic [REG_W-1:0] srcs [N_SRC];
  logic [N_SRC-1:0] hit;
  logic             stall, accept, flushing;
  hzd_cause_e       cause;

  assign srcs[0] = dec_rt;
  assign srcs[1] = dec_rd;

  hzd_fwd_unit #(.REG_W(REG_W), .N_SRC(N_SRC)) fwd_i (
    .src_reg(srcs), .mem_dst(mem_dst), .mem_wr(mem_wr), .hit(hit)
  );

  hzd_redirect #(.FLUSH_CYC(FLUSH_CYC)) redir_i (
    .clk(clk), .rst(rst), .br_taken(br_taken),
    .accept(accept), .flushing(flushing)
  );

  hzd_stall_unit stall_i (
    .clk(clk), .rst(rst), .mem_load(mem_load), .any_hit(|hit),
    .flushing(flushing), .stall(stall)
  );

  always_comb begin
    if (flushing)   cause = CAUSE_BRANCH;
    else if (stall) cause = CAUSE_LOAD_USE;
    else            cause = CAUSE_NONE;
  end

  assign fwd_a   = hit[0] && !stall;
  assign fwd_b   = hit[1] && !stall;
  assign pc_hold = (cause == CAUSE_LOAD_USE);
  assign bubble  = (cause != CAUSE_NONE);
  assign flush   = (cause == CAUSE_BRANCH);

  // ID/EX control register: an all-zero word is the no-op.
  always_ff @(posedge clk) begin
    if (rst)         ex_ctrl <= '0;
    else if (bubble) ex_ctrl <= '0;
    else             ex_ctrl <= dec_ctrl;
  end

  always_ff @(posedge clk) begin
    if (rst)          pc <= '0;
    else if (accept)  pc <= br_target;
    else if (!pc_hold) pc <= pc + STEP;
  end
endmodule

// File: rtl/hzd_ctrl3_chk.sv
module hzd_ctrl3_chk #(
  parameter int REG_W  = 5,
  parameter int CTRL_W = 8,
  parameter int PC_W   = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [REG_W-1:0]  mem_dst,
  input logic [CTRL_W-1:0] dec_ctrl,
  input logic              fwd_a,
  input logic              fwd_b,
  input logic              pc_hold,
  input logic              bubble,
  input logic              flush,
  input logic [CTRL_W-1:0] ex_ctrl,
  input logic [PC_W-1:0]   pc
);
  a_r4_no_fwd_reg0: assert property (@(posedge clk) disable iff (rst)
    (mem_dst == '0) |-> (!fwd_a && !fwd_b && !pc_hold));

  a_r5_hold_bubbles: assert property (@(posedge clk) disable iff (rst)
    pc_hold |-> (bubble && !fwd_a && !fwd_b));

  a_r5_pc_frozen: assert property (@(posedge clk) disable iff (rst)
    pc_hold |=> (pc == $past(pc)));

  a_r6_single_stall: assert property (@(posedge clk) disable iff (rst)
    pc_hold |=> !pc_hold);

  a_r7_ctrl_passes: assert property (@(posedge clk) disable iff (rst)
    !bubble |=> (ex_ctrl == $past(dec_ctrl)));

  a_r8_squash_noop: assert property (@(posedge clk) disable iff (rst)
    flush |=> (ex_ctrl == '0));

  a_r10_flush_wins: assert property (@(posedge clk) disable iff (rst)
    flush |-> (!pc_hold && bubble));
endmodule

bind hzd_ctrl3 hzd_ctrl3_chk #(.REG_W(REG_W), .CTRL_W(CTRL_W), .PC_W(PC_W)) chk_i (
  .clk(clk), .rst(rst), .mem_dst(mem_dst), .dec_ctrl(dec_ctrl),
  .fwd_a(fwd_a), .fwd_b(fwd_b), .pc_hold(pc_hold), .bubble(bubble),
  .flush(flush), .ex_ctrl(ex_ctrl), .pc(pc)
);

// File: tb/hzd_ctrl3_tb_top.sv
`timescale 1ns/1ps
module hzd_ctrl3_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  dec_rt, dec_rd, mem_dst;
  logic [7:0]  dec_ctrl, ex_ctrl;
  logic        mem_wr, mem_load, br_taken;
  logic [15:0] br_target, pc;
  logic        fwd_a, fwd_b, pc_hold, bubble, flush;
  int          total = 0;
  int          bad = 0;

  always #2.5 clk = ~clk;

  hzd_ctrl3 dut_i (
    .clk(clk), .rst(rst), .dec_rt(dec_rt), .dec_rd(dec_rd), .dec_ctrl(dec_ctrl),
    .mem_dst(mem_dst), .mem_wr(mem_wr), .mem_load(mem_load),
    .br_taken(br_taken), .br_target(br_target),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .pc_hold(pc_hold), .bubble(bubble),
    .flush(flush), .ex_ctrl(ex_ctrl), .pc(pc)
  );

  typedef struct packed {
    logic [4:0] rt, rd, dst;
    logic       wr, ld, ea, eb, eh;
    logic [7:0] req;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{5'd3, 5'd7, 5'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd2},
    '{5'd3, 5'd7, 5'd7, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'd3},
    '{5'd5, 5'd5, 5'd5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'd3},
    '{5'd0, 5'd0, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd4},
    '{5'd4, 5'd9, 5'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd4},
    '{5'd2, 5'd9, 5'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'd5},
    '{5'd1, 5'd6, 5'd6, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'd5},
    '{5'd1, 5'd6, 5'd8, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd5},
    '{5'd0, 5'd0, 5'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd4}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    dec_rt = 5'd0; dec_rd = 5'd0; dec_ctrl = 8'h00; mem_dst = 5'd0;
    mem_wr = 1'b0; mem_load = 1'b0; br_taken = 1'b0; br_target = 16'h0;
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] p;
    idle();
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1", "ex_ctrl", int'(ex_ctrl), 0);
    chk("R1", "pc", int'(pc), 0);
    chk("R1", "pc_hold", int'(pc_hold), 0);
    chk("R1", "flush", int'(flush), 0);
    chk("R1", "bubble", int'(bubble), 0);

    // Table walk: forwarding and load-use decisions (R2 R3 R4 R5)
    for (int i = 0; i < 9; i++) begin
      idle();
      tick();
      dec_rt = VECS[i].rt; dec_rd = VECS[i].rd; mem_dst = VECS[i].dst;
      mem_wr = VECS[i].wr; mem_load = VECS[i].ld;
      #1;
      chk($sformatf("R%0d", VECS[i].req), $sformatf("fwd_a v%0d", i), int'(fwd_a), int'(VECS[i].ea));
      chk($sformatf("R%0d", VECS[i].req), $sformatf("fwd_b v%0d", i), int'(fwd_b), int'(VECS[i].eb));
      chk($sformatf("R%0d", VECS[i].req), $sformatf("pc_hold v%0d", i), int'(pc_hold), int'(VECS[i].eh));
      tick();
    end

    // R7 sequential flow
    idle();
    tick();
    p = pc;
    dec_ctrl = 8'h5A;
    tick();
    chk("R7", "ex_ctrl", int'(ex_ctrl), 'h5A);
    chk("R7", "pc step", int'(pc), int'(p + 16'd4));
    chk("R11", "no flush", int'(flush), 0);

    // R5 / R6 load-use stall then forward
    p = pc;
    dec_rt = 5'd6; mem_dst = 5'd6; mem_wr = 1'b1; mem_load = 1'b1; dec_ctrl = 8'h33;
    #1;
    chk("R5", "pc_hold", int'(pc_hold), 1);
    chk("R5", "bubble", int'(bubble), 1);
    chk("R5", "fwd_a in stall", int'(fwd_a), 0);
    tick();
    chk("R5", "pc frozen", int'(pc), int'(p));
    chk("R5", "ex_ctrl noop", int'(ex_ctrl), 0);
    chk("R6", "second pc_hold", int'(pc_hold), 0);
    chk("R6", "fwd_a after stall", int'(fwd_a), 1);
    tick();
    chk("R6", "pc resumes", int'(pc), int'(p + 16'd4));
    chk("R6", "ex_ctrl passes", int'(ex_ctrl), 'h33);

    // R8 / R9 taken branch, second taken ignored in refill cycle
    idle();
    dec_ctrl = 8'h77; br_taken = 1'b1; br_target = 16'h0100;
    #1;
    chk("R8", "flush c0", int'(flush), 1);
    chk("R8", "bubble c0", int'(bubble), 1);
    tick();
    chk("R8", "pc target", int'(pc), 'h100);
    chk("R8", "ex_ctrl c0", int'(ex_ctrl), 0);
    br_target = 16'h0200;
    #1;
    chk("R8", "flush c1", int'(flush), 1);
    tick();
    chk("R9", "pc not reloaded", int'(pc), 'h104);
    chk("R8", "ex_ctrl c1", int'(ex_ctrl), 0);
    br_taken = 1'b0;
    #1;
    chk("R8", "flush ends", int'(flush), 0);
    tick();
    chk("R8", "ex_ctrl after", int'(ex_ctrl), 'h77);
    chk("R8", "pc after", int'(pc), 'h108);

    // R10 flush beats stall in the same cycle
    idle();
    tick();
    dec_rt = 5'd9; mem_dst = 5'd9; mem_wr = 1'b1; mem_load = 1'b1;
    br_taken = 1'b1; br_target = 16'h0400;
    #1;
    chk("R10", "pc_hold", int'(pc_hold), 0);
    chk("R10", "flush", int'(flush), 1);
    tick();
    chk("R10", "pc target", int'(pc), 'h400);
    idle();
    tick(); tick();

    // R11 not-taken: no flush, no penalty
    p = pc;
    dec_ctrl = 8'h11;
    #1;
    chk("R11", "flush", int'(flush), 0);
    tick();
    chk("R11", "pc step", int'(pc), int'(p + 16'd4));
    chk("R11", "ex_ctrl", int'(ex_ctrl), 'h11);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule